// File: doc/BRIEF.md
# Streaming Scharr Gradient Filter

This block takes a single-channel 8-bit image in raster order. It returns two gradient images of the same size, one horizontal and one vertical. Both are computed over a 3x3 neighbourhood with Scharr weights of 3, 10 and 3. Pixels enter on a valid/ready port, and the first pixel of a frame carries a start marker. The frame's width and height are read from two configuration inputs when that first pixel arrives, and each may take any value from 1 up to the elaborated maximum.

Two line stores hold the two most recent rows. A two-column window register holds the two most recent columns. Together with the incoming pixel they form the full neighbourhood, which a fixed-coefficient convolver reduces to the X and Y results. Neighbours that fall outside the frame are taken as zero. Each output is aligned to the centre of its window. After the last input pixel the block produces the last row and the last column by itself. The two results leave on separate streams that always move together: if either consumer is not ready, the whole pipeline stalls. One elaboration parameter selects the output type, either a 16-bit two's-complement value or an 8-bit unsigned value clamped to 0..255.

Top module: `scharr_grad`

## Requirements
- R1: gx for the pixel at (r,c) equals 3*(p(r-1,c+1)-p(r-1,c-1)) + 10*(p(r,c+1)-p(r,c-1)) + 3*(p(r+1,c+1)-p(r+1,c-1)), where p is the input image and r counts rows downward.
- R2: gy for the pixel at (r,c) equals 3*(p(r+1,c-1)-p(r-1,c-1)) + 10*(p(r+1,c)-p(r-1,c)) + 3*(p(r+1,c+1)-p(r-1,c+1)).
- R3: Any neighbour outside the frame (row or column below 0, or at or beyond the configured height or width) counts as the value 0.
- R4: With SAT8=0 the data ports are 16 bits wide and carry the exact signed result, whose magnitude never exceeds 4080. With SAT8=1 they are 8 bits wide and carry the result clamped, so negative values give 0 and values above 255 give 255.
- R5: Each frame yields exactly width*height results per stream in raster order. out_sof is 1 on the first result of the frame, and out_eol is 1 exactly on the last result of each row.
- R6: With both output readies held high, the result centred at (r-1,c-1) is presented the cycle after the input pixel at (r,c) is accepted. In particular, the first result of a frame that is at least 2x2 appears one cycle after the input pixel at (1,1) is accepted.
- R7: After the last input pixel is accepted, every remaining result is produced with in_valid low, and no input is accepted during that flush.
- R8: gx_valid and gy_valid are always equal. A result transfers only when gx_ready and gy_ready are both 1. While either ready is 0, the valids, data and markers hold steady.
- R9: Between frames and after reset, no result is produced. A pixel offered without in_sof is accepted (in_ready=1) and discarded. A pixel with in_sof=1 starts a frame and latches cfg_width and cfg_height.
- R10: Any width from 1 to MAX_W and any height from 1 to MAX_H is processed correctly, including 1x1, a single row, a single column and the full maximum in either dimension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | $clog2(MAX_W+1) | Frame width in pixels, latched at frame start |
| cfg_height | input | $clog2(MAX_H+1) | Frame height in rows, latched at frame start |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle when high together with in_valid |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | 8 | Input pixel, unsigned |
| gx_valid | output | 1 | Horizontal-gradient result valid |
| gx_ready | input | 1 | Horizontal-gradient consumer ready |
| gx_data | output | 16 or 8 | Horizontal gradient (signed 16-bit or clamped 8-bit) |
| gy_valid | output | 1 | Vertical-gradient result valid |
| gy_ready | input | 1 | Vertical-gradient consumer ready |
| gy_data | output | 16 or 8 | Vertical gradient (signed 16-bit or clamped 8-bit) |
| out_sof | output | 1 | First result of the frame |
| out_eol | output | 1 | Last result of a row |

## Verification
Each result is registered on the step that consumes the pixel one row below and one column to the right of its centre, so it is due exactly one cycle after that pixel is accepted when neither consumer stalls. The bench drives inputs on the falling edge and reads the outputs 1 ns later, within the same cycle, before the next rising edge. It records the cycle number at which pixel (1,1) is accepted and requires the first result in the following cycle. Under backpressure the bench counts a transfer only in a cycle where both readies it drove are high. In the cycle after any stalled cycle it requires the held values to be unchanged. The trailing row and column are checked by dropping in_valid after the last pixel and waiting for the full result count.

// File: rtl/scharr_pkg.sv
package scharr_pkg;

    localparam int PIX_W = 8;
    localparam int ACC_W = 14;
    localparam int GRAD_MAX = 4080;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    // One column of the 3x3 neighbourhood: top is the oldest row.
    typedef struct packed {
        pix_t top;
        pix_t mid;
        pix_t bot;
    } col_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } state_t;

    function automatic acc_t span(pix_t lo, pix_t hi);
        return acc_t'({(ACC_W-PIX_W)'(0), hi}) - acc_t'({(ACC_W-PIX_W)'(0), lo});
    endfunction

    function automatic acc_t times3(acc_t v);
        return (v <<< 1) + v;
    endfunction

    function automatic acc_t times10(acc_t v);
        return (v <<< 3) + (v <<< 1);
    endfunction

    function automatic pix_t clamp8(acc_t v);
        if (v < 0) begin
            return '0;
        end
        if (v > 255) begin
            return '1;
        end
        return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/scharr_line_store.sv
module scharr_line_store #(
    parameter int DEPTH = 1024,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // Write-after-read in the same cycle: the reader sees the old row.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr[IW-1:0]] <= wr_data;
        end
    end

    // The padding column (addr == DEPTH) reads as zero.
    assign rd_data = (addr < AW'(DEPTH)) ? mem[addr[IW-1:0]] : '0;

endmodule

// File: rtl/scharr_conv.sv
module scharr_conv
    import scharr_pkg::*;
#(
    parameter bit SAT8    = 1'b0,
    localparam int OUT_W  = SAT8 ? 8 : 16
) (
    input  col_t             left,
    input  col_t             centre,
    input  col_t             right,
    output acc_t             gx_raw,
    output acc_t             gy_raw,
    output logic [OUT_W-1:0] gx_fmt,
    output logic [OUT_W-1:0] gy_fmt
);

    // Horizontal derivative: right column minus left column.
    assign gx_raw = times3(span(left.top, right.top))
                  + times10(span(left.mid, right.mid))
                  + times3(span(left.bot, right.bot));

    // Vertical derivative: bottom row minus top row.
    assign gy_raw = times3(span(left.top, left.bot))
                  + times10(span(centre.top, centre.bot))
                  + times3(span(right.top, right.bot));

    if (SAT8) begin : g_clamp
        assign gx_fmt = clamp8(gx_raw);
        assign gy_fmt = clamp8(gy_raw);
    end else begin : g_signed
        assign gx_fmt = OUT_W'(gx_raw);
        assign gy_fmt = OUT_W'(gy_raw);
    end

endmodule

// File: rtl/scharr_grad.sv
module scharr_grad
    import scharr_pkg::*;
#(
    parameter int MAX_W  = 1024,
    parameter int MAX_H  = 1024,
    parameter bit SAT8   = 1'b0,
    localparam int OUT_W = SAT8 ? 8 : 16,
    localparam int CW    = $clog2(MAX_W + 1),
    localparam int RW    = $clog2(MAX_H + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    cfg_width,
    input  logic [RW-1:0]    cfg_height,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sof,
    input  logic [7:0]       in_pix,
    output logic             gx_valid,
    input  logic             gx_ready,
    output logic [OUT_W-1:0] gx_data,
    output logic             gy_valid,
    input  logic             gy_ready,
    output logic [OUT_W-1:0] gy_data,
    output logic             out_sof,
    output logic             out_eol
);

    localparam int LINES = 2;

    state_t        st;
    logic [CW-1:0] w_lat, c_cnt;
    logic [RW-1:0] h_lat, r_cnt;
    logic          o_vld;

    // Virtual raster covers rows 0..height and columns 0..width; the extra
    // row and column are padding steps that flush the trailing results.
    logic room, in_img, last_col, last_row, step, lb_we;
    assign room     = !o_vld || (gx_ready && gy_ready);
    assign in_img   = (r_cnt < h_lat) && (c_cnt < w_lat);
    assign last_col = (c_cnt == w_lat);
    assign last_row = (r_cnt == h_lat);
    assign step     = (st == ST_RUN) && room && (!in_img || in_valid);
    assign lb_we    = step && in_img;

    always_comb begin
        if (st == ST_IDLE) begin
            in_ready = !in_sof;
        end else begin
            in_ready = in_img && room;
        end
    end

    // Line stores: entry k holds the row k+1 above the current one.
    pix_t lb_q [LINES];
    pix_t lb_d [LINES];

    for (genvar k = 0; k < LINES; k++) begin : g_line
        if (k == 0) begin : g_first
            assign lb_d[k] = in_pix;
        end else begin : g_chain
            assign lb_d[k] = lb_q[k-1];
        end
        scharr_line_store #(
            .DEPTH (MAX_W),
            .DW    (PIX_W)
        ) i_line (
            .clk     (clk),
            .wr_en   (lb_we),
            .addr    (c_cnt),
            .wr_data (lb_d[k]),
            .rd_data (lb_q[k])
        );
    end

    // Incoming column, with zero substituted outside the frame.
    col_t new_col;
    always_comb begin
        new_col.top = (r_cnt >= RW'(2) && !last_col) ? lb_q[1] : '0;
        new_col.mid = (r_cnt != '0 && !last_col)     ? lb_q[0] : '0;
        new_col.bot = in_img ? in_pix : '0;
    end

    // Two previous columns of the window.
    col_t win_near, win_far;
    always_ff @(posedge clk) begin
        if (rst) begin
            win_near <= '0;
            win_far  <= '0;
        end else if (step) begin
            win_near <= new_col;
            win_far  <= (c_cnt == '0) ? '0 : win_near;
        end
    end

    acc_t             gx_raw, gy_raw;
    logic [OUT_W-1:0] gx_fmt, gy_fmt;

    scharr_conv #(.SAT8(SAT8)) i_conv (
        .left   (win_far),
        .centre (win_near),
        .right  (new_col),
        .gx_raw (gx_raw),
        .gy_raw (gy_raw),
        .gx_fmt (gx_fmt),
        .gy_fmt (gy_fmt)
    );

    // Frame sequencing.
    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            w_lat <= '0;
            h_lat <= '0;
            c_cnt <= '0;
            r_cnt <= '0;
        end else if (st == ST_IDLE) begin
            if (in_valid && in_sof) begin
                st    <= ST_RUN;
                w_lat <= cfg_width;
                h_lat <= cfg_height;
                c_cnt <= '0;
                r_cnt <= '0;
            end
        end else if (step) begin
            if (last_col) begin
                c_cnt <= '0;
                if (last_row) begin
                    st <= ST_IDLE;
                end else begin
                    r_cnt <= r_cnt + RW'(1);
                end
            end else begin
                c_cnt <= c_cnt + CW'(1);
            end
        end
    end

    // Shared output register for both streams.
    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld   <= 1'b0;
            gx_data <= '0;
            gy_data <= '0;
            out_sof <= 1'b0;
            out_eol <= 1'b0;
        end else if (step) begin
            o_vld   <= (r_cnt != '0) && (c_cnt != '0);
            gx_data <= gx_fmt;
            gy_data <= gy_fmt;
            out_sof <= (r_cnt == RW'(1)) && (c_cnt == CW'(1));
            out_eol <= last_col;
        end else if (gx_ready && gy_ready) begin
            o_vld <= 1'b0;
        end
    end

    assign gx_valid = o_vld;
    assign gy_valid = o_vld;

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst) (o_vld && !(gx_ready && gy_ready)) |=> (o_vld && $stable(gx_data) && $stable(gy_data) && $stable(out_sof) && $stable(out_eol))) else $error("stalled result changed"); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst) (st == ST_IDLE && !o_vld) |=> !o_vld) else $error("result outside a frame"); // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) (st == ST_RUN) |-> (c_cnt <= w_lat && r_cnt <= h_lat)) else $error("raster position beyond frame"); // R10
    AST_GRAD_RANGE: assert property (@(posedge clk) disable iff (rst) (st == ST_RUN) |-> (gx_raw <= GRAD_MAX && gx_raw >= -GRAD_MAX && gy_raw <= GRAD_MAX && gy_raw >= -GRAD_MAX)) else $error("gradient magnitude too large"); // R4
    AST_FLUSH_NO_INPUT: assert property (@(posedge clk) disable iff (rst) (st == ST_RUN && r_cnt == h_lat) |-> !in_ready) else $error("input taken during flush"); // R7

endmodule

// File: tb/test_scharr_grad.sv
`timescale 1ns/1ps
module test_scharr_grad;

    localparam int MW = 16;
    localparam int MH = 16;
    localparam int CWB = $clog2(MW + 1);
    localparam int RWB = $clog2(MH + 1);

    typedef struct packed {
        int w;
        int h;
        int kind;
        int bp;
    } frame_vec_t;

    // Width, height, pattern, backpressure
    localparam frame_vec_t VECS [8] = '{
        '{5, 4, 0, 0},
        '{6, 5, 1, 1},
        '{16, 3, 2, 0},
        '{3, 16, 2, 1},
        '{1, 1, 3, 0},
        '{7, 1, 4, 1},
        '{1, 6, 0, 0},
        '{4, 4, 3, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CWB-1:0] cfg_width = '0;
    logic [RWB-1:0] cfg_height = '0;
    logic in_valid = 1'b0, in_sof = 1'b0;
    logic [7:0] in_pix = '0;
    logic gx_ready = 1'b1, gy_ready = 1'b1;
    logic in_ready, gx_valid, gy_valid, out_sof, out_eol;
    logic [15:0] gx_data, gy_data;
    logic s_in_ready, s_gx_valid, s_gy_valid, s_out_sof, s_out_eol;
    logic [7:0] s_gx_data, s_gy_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] img [0:MW*MH-1];

    always #2 clk = ~clk;

    scharr_grad #(.MAX_W(MW), .MAX_H(MH), .SAT8(1'b0)) i_scharr_grad (
        .clk, .rst, .cfg_width, .cfg_height, .in_valid, .in_ready, .in_sof, .in_pix,
        .gx_valid, .gx_ready, .gx_data, .gy_valid, .gy_ready, .gy_data, .out_sof, .out_eol
    );

    scharr_grad #(.MAX_W(MW), .MAX_H(MH), .SAT8(1'b1)) i_scharr_grad_sat (
        .clk, .rst, .cfg_width, .cfg_height, .in_valid, .in_ready(s_in_ready), .in_sof, .in_pix,
        .gx_valid(s_gx_valid), .gx_ready, .gx_data(s_gx_data), .gy_valid(s_gy_valid),
        .gy_ready, .gy_data(s_gy_data), .out_sof(s_out_sof), .out_eol(s_out_eol)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pattern(int kind, int r, int c);
        case (kind)
            0:       return 8'((r * 16 + c * 5) % 256);
            1:       return (((r + c) % 2) == 1) ? 8'd255 : 8'd0;
            2:       return 8'(((r * 37 + c * 91 + 13) ^ (r * c)) % 256);
            3:       return 8'd200;
            default: return ((c % 2) == 1) ? 8'd255 : 8'd0;
        endcase
    endfunction

    function automatic int px(int w, int h, int r, int c);
        if (r < 0 || c < 0 || r >= h || c >= w) return 0;
        return int'(img[r * w + c]);
    endfunction

    function automatic int clampi(int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    task automatic run_frame(input int w, input int h, input int kind, input int bp);
        int nin, nout, cyc, t_in;
        bit stall_prev;
        int pgx, pgy;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                img[r * w + c] = pattern(kind, r, c);
        cfg_width = CWB'(w);
        cfg_height = RWB'(h);
        nin = 0; nout = 0; cyc = 0; t_in = -10; stall_prev = 0; pgx = 0; pgy = 0;
        while (nout < w * h && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            gx_ready = (bp == 0) || ((cyc % 3) != 1);
            gy_ready = (bp == 0) || ((cyc % 4) != 2);
            in_valid = (nin < w * h);
            in_pix = (nin < w * h) ? img[nin] : 8'd0;
            in_sof = (nin == 0);
            #1;
            if (stall_prev) begin
                // R8: held result after a stall
                check(gx_valid && int'($signed(gx_data)) == pgx && int'($signed(gy_data)) == pgy,
                      "R8 hold", int'($signed(gx_data)), pgx);
            end
            if (gx_valid !== gy_valid || s_gx_valid !== gx_valid || s_gy_valid !== gx_valid)
                check(1'b0, "R8 lockstep", int'(gy_valid), int'(gx_valid));
            if (gx_valid && gx_ready && gy_ready) begin
                int r, c, ex, ey;
                string tx, ty;
                r = nout / w;
                c = nout % w;
                ex = 3 * (px(w, h, r-1, c+1) - px(w, h, r-1, c-1))
                   + 10 * (px(w, h, r, c+1) - px(w, h, r, c-1))
                   + 3 * (px(w, h, r+1, c+1) - px(w, h, r+1, c-1));
                ey = 3 * (px(w, h, r+1, c-1) - px(w, h, r-1, c-1))
                   + 10 * (px(w, h, r+1, c) - px(w, h, r-1, c))
                   + 3 * (px(w, h, r+1, c+1) - px(w, h, r-1, c+1));
                tx = (r == 0 || c == 0 || r == h-1 || c == w-1) ? "R3 border gx" : "R1 gx";
                ty = (r == 0 || c == 0 || r == h-1 || c == w-1) ? "R3 border gy" : "R2 gy";
                check(int'($signed(gx_data)) == ex, tx, int'($signed(gx_data)), ex);
                check(int'($signed(gy_data)) == ey, ty, int'($signed(gy_data)), ey);
                check(int'(s_gx_data) == clampi(ex), "R4 clamp gx", int'(s_gx_data), clampi(ex));
                check(int'(s_gy_data) == clampi(ey), "R4 clamp gy", int'(s_gy_data), clampi(ey));
                check(out_sof == (nout == 0) && s_out_sof == out_sof, "R5 sof", int'(out_sof), int'(nout == 0));
                check(out_eol == (c == w-1) && s_out_eol == out_eol, "R5 eol", int'(out_eol), int'(c == w-1));
                if (nout == 0 && bp == 0 && w >= 2 && h >= 2)
                    check(cyc == t_in + 1, "R6 latency", cyc, t_in + 1);
                nout++;
            end
            stall_prev = gx_valid && !(gx_ready && gy_ready);
            pgx = int'($signed(gx_data));
            pgy = int'($signed(gy_data));
            if (in_valid && in_ready) begin
                if (nin == w + 1) t_in = cyc;
                nin++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
        gx_ready = 1'b1;
        gy_ready = 1'b1;
        // R7: flush completes with in_valid low; R10: size honoured
        check(nout == w * h && nin == w * h, "R7 R10 count", nout, w * h);
        repeat (4) begin
            @(negedge clk);
            #1;
            check(!gx_valid && !s_gx_valid, "R9 quiet after frame", int'(gx_valid), 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset state
        check(!gx_valid && !gy_valid && !s_gx_valid, "R9 reset", int'(gx_valid), 0);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            run_frame(VECS[i].w, VECS[i].h, VECS[i].kind, VECS[i].bp);
        end

        // R9: pixels without a start marker are taken and dropped
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof = 1'b0;
            in_pix = 8'(i * 40);
            #1;
            check(in_ready == 1'b1, "R9 discard ready", int'(in_ready), 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) begin
            @(negedge clk);
            #1;
            check(!gx_valid, "R9 discard silent", int'(gx_valid), 0);
        end
        run_frame(4, 3, 2, 0);

        // R9: reset in mid-frame, then a clean frame
        cfg_width = CWB'(5);
        cfg_height = RWB'(5);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof = (i == 0);
            in_pix = 8'(i * 25);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!gx_valid && !s_gx_valid, "R9 reset mid-frame", int'(gx_valid), 0);
        run_frame(5, 5, 1, 1);
        run_frame(16, 16, 2, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule